// File: doc/BRIEF.md
# Indirect switch register access engine

This block performs one read or one write of an internal register inside a multi-port switch. Such a switch does not map its internal registers onto the management bus directly. It exposes only two management-visible words: a command word at offset 0 and a data word at offset 1. The engine turns each request into the indirect sequence that the switch expects:

- It polls the busy flag.
- It stores data and a packed command word.
- It polls the busy flag again.
- For a read, it fetches the result from the data word.

The requester supplies a direction, a device/port selector, a register selector and, for a write, a data word. It then waits for a one-cycle completion pulse or a one-cycle error pulse. The downstream side is a word-level management-bus master with a request/done/error handshake. It stands in for the serial management interface, whose bit-level signalling belongs to a separate block. Busy polling is bounded: a poll loop that never sees the flag drop ends the access with a timeout error. Any transfer failure reported by the bus also ends the access at once.

Top module: `swreg_engine`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `req_ready` is 1 and `rsp_done`, `rsp_err`, `rsp_tmo` and `mb_req` are 0. An access in flight is dropped when reset is asserted.
- R2: The command word placed on `mb_wdata` for offset 0 has the following fields:
  - bits 15:12 are 4'b1001;
  - bits 11:10 are the opcode, 2'b10 for a read and 2'b01 for a write;
  - bits 9:5 are the device selector;
  - bits 4:0 are the register selector.
- R3: A write issues its bus transfers in this order:
  - reads of offset 0 until bit 15 of the returned word is 0;
  - one write of the request data to offset 1;
  - one write of the command word to offset 0;
  - reads of offset 0 until bit 15 is 0.

  `rsp_done` then pulses.
- R4: A read issues its bus transfers in this order:
  - reads of offset 0 until bit 15 is 0;
  - one write of the command word to offset 0;
  - reads of offset 0 until bit 15 is 0;
  - one read of offset 1.

  `rsp_done` then pulses with `rsp_rdata` equal to the word returned by that last read.
- R5: Each busy poll repeats the offset-0 read for as long as bit 15 of the returned word is 1. Each poll phase therefore makes exactly one more read than the number of busy words returned to it.
- R6: If `POLL_LIMIT` consecutive reads within one poll phase return bit 15 set, the access ends after the last of them with `rsp_err` and `rsp_tmo` both 1, and no further transfer is issued. A phase that sees `POLL_LIMIT`-1 busy reads followed by a clear one continues normally.
- R7: A transfer that ends with `mb_err` ends the access. From the next cycle `rsp_err` is 1, `rsp_tmo` is 0 and `mb_req` is 0.
- R8: `req_ready` is low from the cycle after a request is accepted until the completion or error pulse. A request presented while `req_ready` is low is ignored and never reaches the bus.
- R9: Only bits 4:0 of `req_dev` and `req_reg` are used. Higher bits have no effect on the command word.
- R10: `rsp_done` and `rsp_err` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to accept a request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_dev | input | ADDR_IN_W | Device/port selector (low 5 bits used) |
| req_reg | input | ADDR_IN_W | Register selector (low 5 bits used) |
| req_wdata | input | 16 | Data for a write access |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | One-cycle error pulse |
| rsp_tmo | output | 1 | With `rsp_err`: 1 = busy timeout, 0 = bus failure |
| rsp_rdata | output | 16 | Result of the last completed read |
| mb_req | output | 1 | Bus transfer request; held until done or error |
| mb_we | output | 1 | 1 = bus write, 0 = bus read |
| mb_ofs | output | MB_OFS_W | Bus register offset (0 command, 1 data) |
| mb_wdata | output | 16 | Bus write data |
| mb_rdata | input | 16 | Bus read data, valid with `mb_done` |
| mb_done | input | 1 | Bus transfer completed |
| mb_err | input | 1 | Bus transfer failed |

## Verification
The bench targets the following corner cases:

- **Poll limit.** It runs a poll phase one busy read short of the limit and another exactly at the limit. An off-by-one counter would either time out an access that should succeed or let one extra read through.
- **Post-command timeout.** It times out the poll phase that follows the command. An engine that reset or skipped the counter there would hang or complete falsely.
- **Bus failure mid-sequence.** It injects a bus failure partway through. An engine that ignored the failure would carry on issuing transfers or report success.
- **Requests while busy.** It presents a conflicting request during an access and then reads the target register back. An engine that latched the second request would overwrite the stored value.
- **Over-wide selectors.** It supplies selectors wider than 5 bits and checks that they land on the same register as their masked values.

// File: rtl/swreg_pkg.sv
`timescale 1ns/1ps
package swreg_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned FLD_W    = 5;
  localparam int unsigned BUSY_BIT = 15;

  localparam logic [3:0] CMD_HDR = 4'b1001;
  localparam logic [1:0] OP_RD   = 2'b10;
  localparam logic [1:0] OP_WR   = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PREPOLL  = 3'd1,
    ST_PUTDATA  = 3'd2,
    ST_PUTCMD   = 3'd3,
    ST_POSTPOLL = 3'd4,
    ST_GETDATA  = 3'd5
  } seq_st_t;
endpackage

// File: rtl/swreg_cmd_pack.sv
`timescale 1ns/1ps
module swreg_cmd_pack
  import swreg_pkg::*;
#(
  parameter int unsigned ADDR_IN_W = 8
) (
  input  logic                 is_write,
  input  logic [ADDR_IN_W-1:0] dev,
  input  logic [ADDR_IN_W-1:0] rsel,
  output logic [WORD_W-1:0]    cmd
);
  logic [FLD_W-1:0] dev_f;
  logic [FLD_W-1:0] reg_f;
  logic [1:0]       op;

  generate
    if (ADDR_IN_W > FLD_W) begin : g_trim
      logic unused_hi;
      assign unused_hi = ^{dev[ADDR_IN_W-1:FLD_W], rsel[ADDR_IN_W-1:FLD_W]};
      assign dev_f = dev[FLD_W-1:0];
      assign reg_f = rsel[FLD_W-1:0];
    end else begin : g_pad
      assign dev_f = FLD_W'(dev);
      assign reg_f = FLD_W'(rsel);
    end
  endgenerate

  assign op  = is_write ? OP_WR : OP_RD;
  assign cmd = {CMD_HDR, op, dev_f, reg_f};
endmodule

// File: rtl/swreg_poll_ctr.sv
`timescale 1ns/1ps
module swreg_poll_ctr #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == LAST_V);
endmodule

// File: rtl/swreg_seq_fsm.sv
`timescale 1ns/1ps
module swreg_seq_fsm
  import swreg_pkg::*;
#(
  parameter int unsigned MB_OFS_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                is_write,
  input  logic [WORD_W-1:0]   cmd_word,
  input  logic [WORD_W-1:0]   wr_word,
  output logic                idle,
  output logic                mb_req,
  output logic                mb_we,
  output logic [MB_OFS_W-1:0] mb_ofs,
  output logic [WORD_W-1:0]   mb_wdata,
  input  logic [WORD_W-1:0]   mb_rdata,
  input  logic                mb_done,
  input  logic                mb_err,
  output logic                poll_clr,
  output logic                poll_inc,
  input  logic                poll_last,
  output logic                fin_done,
  output logic                fin_err,
  output logic                fin_tmo,
  output logic [WORD_W-1:0]   fin_rdata
);
  localparam logic [MB_OFS_W-1:0] CMD_OFS  = '0;
  localparam logic [MB_OFS_W-1:0] DATA_OFS = MB_OFS_W'(1);

  seq_st_t st_q, st_d;
  logic    done_d, err_d, tmo_d, rd_cap;
  logic    in_poll, busy_seen;

  assign in_poll   = (st_q == ST_PREPOLL) || (st_q == ST_POSTPOLL);
  assign busy_seen = mb_rdata[BUSY_BIT];
  assign poll_clr  = !in_poll;
  assign poll_inc  = in_poll && mb_done && busy_seen;

  // next state
  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    tmo_d  = 1'b0;
    rd_cap = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) st_d = ST_PREPOLL;
      end
      ST_PREPOLL: begin
        if (mb_err) begin
          st_d = ST_IDLE; err_d = 1'b1;
        end else if (mb_done) begin
          if (busy_seen) begin
            if (poll_last) begin
              st_d = ST_IDLE; err_d = 1'b1; tmo_d = 1'b1;
            end
          end else begin
            st_d = is_write ? ST_PUTDATA : ST_PUTCMD;
          end
        end
      end
      ST_PUTDATA: begin
        if (mb_err) begin
          st_d = ST_IDLE; err_d = 1'b1;
        end else if (mb_done) begin
          st_d = ST_PUTCMD;
        end
      end
      ST_PUTCMD: begin
        if (mb_err) begin
          st_d = ST_IDLE; err_d = 1'b1;
        end else if (mb_done) begin
          st_d = ST_POSTPOLL;
        end
      end
      ST_POSTPOLL: begin
        if (mb_err) begin
          st_d = ST_IDLE; err_d = 1'b1;
        end else if (mb_done) begin
          if (busy_seen) begin
            if (poll_last) begin
              st_d = ST_IDLE; err_d = 1'b1; tmo_d = 1'b1;
            end
          end else if (is_write) begin
            st_d = ST_IDLE; done_d = 1'b1;
          end else begin
            st_d = ST_GETDATA;
          end
        end
      end
      ST_GETDATA: begin
        if (mb_err) begin
          st_d = ST_IDLE; err_d = 1'b1;
        end else if (mb_done) begin
          st_d = ST_IDLE; done_d = 1'b1; rd_cap = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      fin_done <= 1'b0;
      fin_err  <= 1'b0;
      fin_tmo  <= 1'b0;
    end else begin
      st_q     <= st_d;
      fin_done <= done_d;
      fin_err  <= err_d;
      fin_tmo  <= tmo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin_rdata <= '0;
    end else if (rd_cap) begin
      fin_rdata <= mb_rdata;
    end
  end

  // bus drive decoded from state
  always_comb begin
    idle     = (st_q == ST_IDLE);
    mb_req   = (st_q != ST_IDLE);
    mb_we    = (st_q == ST_PUTDATA) || (st_q == ST_PUTCMD);
    mb_ofs   = ((st_q == ST_PUTDATA) || (st_q == ST_GETDATA)) ? DATA_OFS : CMD_OFS;
    mb_wdata = (st_q == ST_PUTDATA) ? wr_word : cmd_word;
  end
endmodule

// File: rtl/swreg_engine.sv
`timescale 1ns/1ps
module swreg_engine
  import swreg_pkg::*;
#(
  parameter int unsigned ADDR_IN_W  = 8,
  parameter int unsigned MB_OFS_W   = 5,
  parameter int unsigned POLL_LIMIT = 100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_IN_W-1:0] req_dev,
  input  logic [ADDR_IN_W-1:0] req_reg,
  input  logic [WORD_W-1:0]    req_wdata,
  output logic                 rsp_done,
  output logic                 rsp_err,
  output logic                 rsp_tmo,
  output logic [WORD_W-1:0]    rsp_rdata,
  output logic                 mb_req,
  output logic                 mb_we,
  output logic [MB_OFS_W-1:0]  mb_ofs,
  output logic [WORD_W-1:0]    mb_wdata,
  input  logic [WORD_W-1:0]    mb_rdata,
  input  logic                 mb_done,
  input  logic                 mb_err
);
  logic              idle, accept;
  logic [WORD_W-1:0] cmd_new;
  logic [WORD_W-1:0] cmd_q, wdata_q;
  logic              wr_q;
  logic              poll_clr, poll_inc, poll_last;

  assign req_ready = idle;
  assign accept    = req_valid && idle;

  swreg_cmd_pack #(.ADDR_IN_W(ADDR_IN_W)) u_pack (
    .is_write (req_write),
    .dev      (req_dev),
    .rsel     (req_reg),
    .cmd      (cmd_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      cmd_q   <= cmd_new;
      wdata_q <= req_wdata;
      wr_q    <= req_write;
    end
  end

  swreg_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (poll_clr),
    .inc   (poll_inc),
    .last  (poll_last)
  );

  swreg_seq_fsm #(.MB_OFS_W(MB_OFS_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .is_write  (wr_q),
    .cmd_word  (cmd_q),
    .wr_word   (wdata_q),
    .idle      (idle),
    .mb_req    (mb_req),
    .mb_we     (mb_we),
    .mb_ofs    (mb_ofs),
    .mb_wdata  (mb_wdata),
    .mb_rdata  (mb_rdata),
    .mb_done   (mb_done),
    .mb_err    (mb_err),
    .poll_clr  (poll_clr),
    .poll_inc  (poll_inc),
    .poll_last (poll_last),
    .fin_done  (rsp_done),
    .fin_err   (rsp_err),
    .fin_tmo   (rsp_tmo),
    .fin_rdata (rsp_rdata)
  );
endmodule

// File: rtl/swreg_engine_chk.sv
`timescale 1ns/1ps
module swreg_engine_chk #(
  parameter int unsigned MB_OFS_W = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                rsp_done,
  input logic                rsp_err,
  input logic                rsp_tmo,
  input logic                mb_req,
  input logic                mb_we,
  input logic [MB_OFS_W-1:0] mb_ofs,
  input logic [15:0]         mb_wdata,
  input logic                mb_done,
  input logic                mb_err
);
  AST_RST_IDLE: assert property (@(posedge clk) !rst_n |-> req_ready && !mb_req); // R1
  AST_CMD_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req && mb_we && (mb_ofs == '0) |-> (mb_wdata[15:12] == 4'b1001) &&
    ((mb_wdata[11:10] == 2'b01) || (mb_wdata[11:10] == 2'b10))); // R2
  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req && !mb_done && !mb_err |=> mb_req && $stable(mb_we) && $stable(mb_ofs) && $stable(mb_wdata)); // R3
  AST_TMO_IS_ERR: assert property (@(posedge clk) disable iff (!rst_n) rsp_tmo |-> rsp_err); // R6
  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req && mb_err |=> !mb_req && rsp_err && !rsp_tmo); // R7
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) mb_req |-> !req_ready); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_done |=> !rsp_done); // R10
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_err |=> !rsp_err); // R10
  AST_RSP_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rsp_done && rsp_err)); // R10
endmodule

bind swreg_engine swreg_engine_chk #(.MB_OFS_W(MB_OFS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .rsp_err   (rsp_err),
  .rsp_tmo   (rsp_tmo),
  .mb_req    (mb_req),
  .mb_we     (mb_we),
  .mb_ofs    (mb_ofs),
  .mb_wdata  (mb_wdata),
  .mb_done   (mb_done),
  .mb_err    (mb_err)
);

// File: tb/swreg_engine_tb.sv
`timescale 1ns/1ps
module swreg_engine_tb;
  localparam int PLIM = 100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [7:0]  req_dev, req_reg;
  logic [15:0] req_wdata;
  logic        rsp_done, rsp_err, rsp_tmo;
  logic [15:0] rsp_rdata;
  logic        mb_req, mb_we;
  logic [4:0]  mb_ofs;
  logic [15:0] mb_wdata;
  logic [15:0] mb_rdata;
  logic        mb_done, mb_err;

  always #10 clk = ~clk;

  swreg_engine #(.ADDR_IN_W(8), .MB_OFS_W(5), .POLL_LIMIT(PLIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_dev(req_dev), .req_reg(req_reg), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_tmo(rsp_tmo), .rsp_rdata(rsp_rdata),
    .mb_req(mb_req), .mb_we(mb_we), .mb_ofs(mb_ofs), .mb_wdata(mb_wdata),
    .mb_rdata(mb_rdata), .mb_done(mb_done), .mb_err(mb_err)
  );

  // switch model behind the two management words
  int pre_busy, post_busy, fail_at;
  int busy_left, xfer_n, log_n;
  logic [21:0] log_q [0:255];
  logic [15:0] sw_mem [0:31][0:31];
  logic [15:0] data_reg, cmd_reg;

  always @(posedge clk) begin
    if (!rst_n) begin
      busy_left <= 0; xfer_n <= 0; log_n <= 0;
      mb_done <= 1'b0; mb_err <= 1'b0; mb_rdata <= '0;
      data_reg <= '0; cmd_reg <= '0;
    end else begin
      mb_done <= 1'b0;
      mb_err  <= 1'b0;
      if (req_valid && req_ready) begin
        busy_left <= pre_busy; xfer_n <= 0; log_n <= 0;
      end else if (mb_req && !mb_done && !mb_err) begin
        xfer_n <= xfer_n + 1;
        if (xfer_n == fail_at) begin
          mb_err <= 1'b1;
        end else begin
          mb_done <= 1'b1;
          if (log_n < 256) log_q[log_n] <= {mb_we, mb_ofs, mb_wdata};
          log_n <= log_n + 1;
          if (mb_we) begin
            if (mb_ofs == 5'd1) data_reg <= mb_wdata;
            else begin
              cmd_reg   <= mb_wdata;
              busy_left <= post_busy;
              if (mb_wdata[11:10] == 2'b01) sw_mem[mb_wdata[9:5]][mb_wdata[4:0]] <= data_reg;
              else if (mb_wdata[11:10] == 2'b10) data_reg <= sw_mem[mb_wdata[9:5]][mb_wdata[4:0]];
            end
          end else if (mb_ofs == 5'd0) begin
            mb_rdata <= {(busy_left > 0), cmd_reg[14:0]};
            if (busy_left > 0) busy_left <= busy_left - 1;
          end else begin
            mb_rdata <= data_reg;
          end
        end
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  logic [15:0] exp_mem [0:31][0:31];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_cmd(input bit w, input logic [7:0] d, input logic [7:0] r);
    return 16'h9000 | (w ? 16'h0400 : 16'h0800) | {6'd0, d[4:0], 5'd0} | {11'd0, r[4:0]};
  endfunction

  task automatic start_req(input bit w, input logic [7:0] d, input logic [7:0] r, input logic [15:0] wd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_dev = d; req_reg = r; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_resp(output bit d, output bit e, output bit t, output logic [15:0] rd);
    int n = 0;
    while (!(rsp_done || rsp_err) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    d = rsp_done; e = rsp_err; t = rsp_tmo; rd = rsp_rdata;
  endtask

  // {wr, dev[8], reg[8], data[16], pre[8], post[8]}
  localparam logic [48:0] VEC [8] = '{
    {1'b1, 8'h02, 8'h04, 16'hA5C3, 8'd0, 8'd0},
    {1'b0, 8'h02, 8'h04, 16'h0000, 8'd0, 8'd0},
    {1'b1, 8'h1B, 8'h1F, 16'h0001, 8'd3, 8'd5},
    {1'b1, 8'hE3, 8'h27, 16'h7E11, 8'd1, 8'd2},
    {1'b0, 8'h03, 8'h07, 16'h0000, 8'd2, 8'd4},
    {1'b0, 8'h1B, 8'h1F, 16'h0000, 8'd0, 8'd7},
    {1'b1, 8'h00, 8'h00, 16'hFFFF, 8'd0, 8'd0},
    {1'b0, 8'h00, 8'h00, 16'h0000, 8'd5, 8'd0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit d, e, t;
    logic [15:0] rd;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_dev = '0; req_reg = '0; req_wdata = '0;
    pre_busy = 0; post_busy = 0; fail_at = -1;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_done && !rsp_err && !mb_req, "R1 in reset", {mb_req, rsp_err, rsp_done, req_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_done && !rsp_err && !rsp_tmo && !mb_req, "R1 after release",
        {rsp_tmo, mb_req, rsp_err, rsp_done, req_ready}, 32'h1);

    // table walk
    for (int i = 0; i < 8; i++) begin
      bit w;
      logic [7:0] dv, rg;
      logic [15:0] dat;
      int p, q;
      string tg;
      w = VEC[i][48]; dv = VEC[i][47:40]; rg = VEC[i][39:32]; dat = VEC[i][31:16];
      p = int'(VEC[i][15:8]); q = int'(VEC[i][7:0]);
      tg = (dv > 8'd31 || rg > 8'd31) ? "R9 masked cmd" : "R2 cmd word";
      pre_busy = p; post_busy = q; fail_at = -1;
      start_req(w, dv, rg, dat);
      wait_resp(d, e, t, rd);
      chk(d && !e, w ? "R3 write done" : "R4 read done", {e, d}, 32'h1);
      chk(log_n == p + q + 4, "R5 transfer count", log_n, p + q + 4);
      if (w) begin
        chk(log_q[p+1] == {1'b1, 5'd1, dat}, "R3 data write first", log_q[p+1], {1'b1, 5'd1, dat});
        chk(log_q[p+2] == {1'b1, 5'd0, exp_cmd(1'b1, dv, rg)}, tg, log_q[p+2], {1'b1, 5'd0, exp_cmd(1'b1, dv, rg)});
        exp_mem[dv[4:0]][rg[4:0]] = dat;
      end else begin
        chk(log_q[p+1] == {1'b1, 5'd0, exp_cmd(1'b0, dv, rg)}, tg, log_q[p+1], {1'b1, 5'd0, exp_cmd(1'b0, dv, rg)});
        chk(log_q[p+q+3][21:16] == 6'b000001, "R4 final data read", log_q[p+q+3][21:16], 6'b000001);
        chk(rd == exp_mem[dv[4:0]][rg[4:0]], "R4 read data", rd, exp_mem[dv[4:0]][rg[4:0]]);
      end
      @(negedge clk);
      chk(!rsp_done && !rsp_err, "R10 single pulse", {rsp_err, rsp_done}, 0);
    end

    // R6 boundary: limit-1 busy reads still succeed
    pre_busy = PLIM - 1; post_busy = 0;
    start_req(1'b1, 8'h05, 8'h05, 16'h0BAD);
    wait_resp(d, e, t, rd);
    chk(d && !e, "R6 limit-1 busy succeeds", {e, d}, 32'h1);
    chk(log_n == PLIM + 3, "R6 limit-1 count", log_n, PLIM + 3);

    // R6 timeout in the first poll phase
    pre_busy = PLIM + 20;
    start_req(1'b1, 8'h06, 8'h01, 16'h1111);
    wait_resp(d, e, t, rd);
    chk(e && t && !d, "R6 pre-poll timeout", {d, t, e}, 32'h3);
    chk(log_n == PLIM, "R6 reads before timeout", log_n, PLIM);
    chk(log_q[PLIM-1][21] == 1'b0, "R6 no write issued", log_q[PLIM-1][21], 0);
    @(negedge clk);
    chk(!mb_req, "R6 bus idle after timeout", mb_req, 0);

    // R6 timeout in the second poll phase
    pre_busy = 0; post_busy = PLIM + 50;
    start_req(1'b0, 8'h06, 8'h02, 16'h0);
    wait_resp(d, e, t, rd);
    chk(e && t, "R6 post-poll timeout", {t, e}, 32'h3);
    chk(log_n == PLIM + 2, "R6 post-poll count", log_n, PLIM + 2);

    // R7 bus failure on the third transfer
    pre_busy = 0; post_busy = 0; fail_at = 2;
    start_req(1'b1, 8'h07, 8'h03, 16'h2222);
    wait_resp(d, e, t, rd);
    chk(e && !t && !d, "R7 bus error reported", {d, t, e}, 32'h1);
    chk(log_n == 2, "R7 aborted at once", log_n, 2);
    chk(!mb_req, "R7 bus released", mb_req, 0);
    fail_at = -1;

    // R8 request while busy is ignored
    pre_busy = 20; post_busy = 0;
    start_req(1'b1, 8'h04, 8'h09, 16'h1234);
    chk(!req_ready, "R8 ready low while busy", req_ready, 0);
    req_valid = 1'b1; req_write = 1'b1; req_dev = 8'h04; req_reg = 8'h09; req_wdata = 16'hDEAD;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    wait_resp(d, e, t, rd);
    chk(d, "R8 first access done", d, 1);
    repeat (5) @(negedge clk);
    chk(!mb_req && req_ready, "R8 no second access", {mb_req, req_ready}, 32'h1);
    pre_busy = 0;
    start_req(1'b0, 8'h04, 8'h09, 16'h0);
    wait_resp(d, e, t, rd);
    chk(d && rd == 16'h1234, "R8 stored value kept", rd, 16'h1234);

    // R1 reset in the middle of an access
    pre_busy = 50;
    start_req(1'b1, 8'h08, 8'h08, 16'h5555);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(req_ready && !mb_req && !rsp_done && !rsp_err, "R1 mid-access reset",
        {rsp_err, rsp_done, mb_req, req_ready}, 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    pre_busy = 0;
    start_req(1'b0, 8'h02, 8'h04, 16'h0);
    wait_resp(d, e, t, rd);
    chk(d && rd == 16'hA5C3, "R4 read after reset", rd, 16'hA5C3);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule